// File: doc/BRIEF.md
# Pulse-Width Single-Wire Frame Receiver

This block listens to an open-drain, single-wire bus on which every bit cell is a low phase followed by a high phase. It measures both phases of each cell with a cycle counter and takes the bit as a 1 when the low phase is the shorter of the two. Because the decision is a comparison and not a sample at a fixed point, the decoder tolerates a wide range of bit rates and duty ratios without tuning.

A one-cycle arm pulse starts a reception and latches the largest number of bytes the caller can accept. Bits are packed most significant first. Every completed byte appears on the byte output with a one-cycle valid strobe. When the frame ends, a one-cycle done pulse comes with an 8-bit result, which is either the number of bytes received or an error code. The code for an empty line is a count of zero, a partial byte or a stuck-low line gives 0xFF, and a frame longer than the byte limit gives 0xFE. A frame is closed by a stop cell: a short low pulse followed by a released line. The block never drives the wire. Its line input is raw and is synchronized inside the block.

Top module: `pw_frame_rx`

## Requirements
- R1: After reset, `done_o` and `byte_valid_o` are low and `status_o` is 0x00.
- R2: A bit decodes as 1 when its low phase lasts fewer cycles than its high phase. It decodes as 0 when the low phase is longer, and also when the two phases are equal.
- R3: Bits are assembled most significant first. After every eighth bit the byte appears on `byte_o` with `byte_valid_o` high for exactly one cycle.
- R4: If no low level is seen within `INIT_WAIT_US` microseconds after arming, the block ends with `done_o` and a status of 0x00, and it delivers no byte.
- R5: If the line stays high for more than `PHASE_TO_US` microseconds after a bit, the frame ends. When the bit count is a multiple of eight, the status is the number of bytes delivered. The last low pulse (the stop cell) is never decoded as a bit.
- R6: A low phase longer than `PHASE_TO_US` microseconds ends the frame with status 0xFF.
- R7: A frame that ends with 1 to 7 bits of an unfinished byte gives status 0xFF.
- R8: If a byte completes when the count already equals the limit, the frame is aborted with status 0xFE. That byte gets no valid strobe, and `byte_valid_o` and `done_o` are never high in the same cycle.
- R9: `done_o` is a one-cycle pulse. `status_o` holds its value until the next done. An arm pulse during a reception has no effect.
- R10: The byte limit is sampled from `max_bytes_i` at arming. Later changes to that input do not affect the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CYC_PER_US` cycles per microsecond |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw bus level, synchronized inside the block |
| arm_i | input | 1 | One-cycle pulse that starts a reception |
| max_bytes_i | input | 8 | Byte limit for the frame, sampled at arming |
| byte_o | output | 8 | Last received byte |
| byte_valid_o | output | 1 | One-cycle strobe for `byte_o` |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| status_o | output | 8 | Byte count, 0xFF (frame error) or 0xFE (overflow) |

## Verification
Byte completion and overflow detection happen on the same falling edge: the edge that ends the eighth bit when the count already equals the limit. The bench provokes this with random frames that carry more bytes than the limit. It expects exactly the first limit-many bytes, one done pulse with 0xFE, and no strobe for the rejected byte. The frame-end timeout and a partial byte meet in the same decision as well. Frames with 1 to 7 trailing bits must report 0xFF, never a count.

// File: rtl/pw_frame_rx.sv
module pw_frame_rx #(
  parameter int CYC_PER_US   = 16,
  parameter int PHASE_TO_US  = 50,
  parameter int INIT_WAIT_US = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic       arm_i,
  input  logic [7:0] max_bytes_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       done_o,
  output logic [7:0] status_o
);
  localparam int PHASE_TO  = CYC_PER_US * PHASE_TO_US;
  localparam int INIT_WAIT = CYC_PER_US * INIT_WAIT_US;
  localparam int TW_RAW    = $clog2(INIT_WAIT + 1);
  localparam int TW        = (TW_RAW < 10) ? 10 : TW_RAW;
  localparam logic [7:0] ST_FRAME_ERR = 8'hFF;
  localparam logic [7:0] ST_OVERFLOW  = 8'hFE;

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_LOW, S_HIGH} state_t;

  state_t        st;
  logic [1:0]    sync;
  logic [TW-1:0] tmr, low_len;
  logic [7:0]    shreg, cnt_q, max_q;
  logic [2:0]    nbit;
  logic          ln, bit_val, active;
  logic [7:0]    nxt_byte;

  assign ln       = sync[1];
  assign bit_val  = low_len < tmr;
  assign nxt_byte = {shreg[6:0], bit_val};
  assign active   = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      low_len <= '0;
      shreg <= '0;
      nbit <= '0;
      cnt_q <= '0;
      max_q <= '0;
      byte_o <= '0;
      byte_valid_o <= 1'b0;
      done_o <= 1'b0;
      status_o <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (arm_i) begin
          st <= S_INIT;
          tmr <= '0;
          cnt_q <= '0;
          nbit <= '0;
          max_q <= max_bytes_i;
        end
        S_INIT: begin
          if (!ln) begin
            st <= S_LOW;
            tmr <= TW'(1);
          end else if (tmr == TW'(INIT_WAIT)) begin
            st <= S_IDLE;
            done_o <= 1'b1;
            status_o <= 8'h00;
          end else tmr <= tmr + 1'b1;
        end
        S_LOW: begin
          if (ln) begin
            low_len <= tmr;
            tmr <= TW'(1);
            st <= S_HIGH;
          end else if (tmr == TW'(PHASE_TO)) begin
            st <= S_IDLE;
            done_o <= 1'b1;
            status_o <= ST_FRAME_ERR;
          end else tmr <= tmr + 1'b1;
        end
        S_HIGH: begin
          if (!ln) begin
            shreg <= nxt_byte;
            nbit <= nbit + 1'b1;
            tmr <= TW'(1);
            st <= S_LOW;
            if (nbit == 3'd7) begin
              if (cnt_q == max_q) begin
                st <= S_IDLE;
                done_o <= 1'b1;
                status_o <= ST_OVERFLOW;
              end else begin
                byte_o <= nxt_byte;
                byte_valid_o <= 1'b1;
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end else if (tmr == TW'(PHASE_TO)) begin
            st <= S_IDLE;
            done_o <= 1'b1;
            status_o <= (nbit == 3'd0) ? cnt_q : ST_FRAME_ERR;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_frame_rx_chk.sv
module pw_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid_o,
  input logic       done_o,
  input logic [7:0] status_o,
  input logic [7:0] cnt_q,
  input logic [7:0] max_q,
  input logic       active
);
  AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid_o && done_o)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> cnt_q <= max_q); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active); // R9
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(status_o)); // R9
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(max_q)); // R10
endmodule

bind pw_frame_rx pw_frame_rx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid_o(byte_valid_o), .done_o(done_o),
  .status_o(status_o), .cnt_q(cnt_q), .max_q(max_q), .active(active)
);

// File: tb/test_pw_frame_rx.sv
module test_pw_frame_rx;
  logic clk = 1'b0, rst_n = 1'b0, line = 1'b1, arm = 1'b0;
  logic [7:0] max_b = 8'd0;
  logic [7:0] byte_o, status_o;
  logic byte_valid_o, done_o;
  int checks = 0, errors = 0;
  int rx_n = 0, done_n = 0;
  logic [7:0] rx [0:15];
  logic [7:0] txd [0:15];
  logic [7:0] last_st;
  bit finished = 0;

  always #4 clk = ~clk;

  pw_frame_rx i_pw_frame_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line), .arm_i(arm), .max_bytes_i(max_b),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .done_o(done_o), .status_o(status_o)
  );

  always @(negedge clk) begin
    if (byte_valid_o) begin
      if (rx_n < 16) rx[rx_n] = byte_o;
      rx_n++;
    end
    if (done_o) begin
      done_n++;
      last_st = status_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit tie);
    int lo, hi;
    if (tie) begin lo = 30; hi = 30; end
    else if (b) begin lo = $urandom_range(10, 22); hi = $urandom_range(40, 60); end
    else begin lo = $urandom_range(40, 60); hi = $urandom_range(10, 22); end
    line = 1'b0; cyc(lo);
    line = 1'b1; cyc(hi);
  endtask

  task automatic do_arm(input int maxb);
    rx_n = 0; done_n = 0;
    @(negedge clk); arm = 1'b1; max_b = 8'(maxb);
    @(negedge clk); arm = 1'b0;
    cyc(5);
  endtask

  function automatic int exp_status(input int nb, input int xb, input int maxb);
    if (nb > maxb) return 8'hFE;
    if (xb != 0) return 8'hFF;
    return nb;
  endfunction

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && done_n == 0; i++) @(negedge clk);
    cyc(3);
  endtask

  task automatic frame(input int nb, input int xb, input int maxb, input bit tie,
                       input bit disturb, input string tag);
    int es, ebytes;
    for (int i = 0; i < nb; i++) txd[i] = tie ? 8'h00 : 8'($urandom);
    do_arm(maxb);
    for (int i = 0; i < nb; i++)
      for (int j = 7; j >= 0; j--) begin
        send_bit(txd[i][j], tie);
        if (disturb && i == 0 && j == 4) begin
          arm = 1'b1; max_b = 8'd0; @(negedge clk); arm = 1'b0;
        end
      end
    for (int j = 0; j < xb; j++) send_bit($urandom_range(0, 1) == 1, 1'b0);
    line = 1'b0; cyc(16); line = 1'b1;
    wait_done(1200);
    es = exp_status(nb, xb, maxb);
    ebytes = (nb > maxb) ? maxb : nb;
    chk(done_n == 1, {tag, " R9 one done pulse"}, done_n, 1);
    chk(last_st == 8'(es), {tag, (es == 8'hFE) ? " R8 overflow" : (es == 8'hFF) ? " R7 partial" : " R5 count"}, last_st, es);
    chk(status_o == 8'(es), {tag, " R9 status held"}, status_o, es);
    chk(rx_n == ebytes, {tag, " R3 byte count"}, rx_n, ebytes);
    for (int i = 0; i < ebytes && i < rx_n; i++)
      chk(rx[i] == txd[i], {tag, tie ? " R2 tie decodes 0" : " R2 R3 byte value"}, rx[i], txd[i]);
  endtask

  initial begin
    for (int i = 0; i < 190000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    chk(byte_valid_o == 1'b0, "R1 valid reset", byte_valid_o, 0);
    chk(status_o == 8'h00, "R1 status reset", status_o, 0);
    rst_n = 1'b1;
    cyc(3);

    // R4: arm with an idle line
    do_arm(4);
    cyc(4100);
    chk(done_n == 1 && last_st == 8'h00, "R4 init timeout", last_st, 0);
    chk(rx_n == 0, "R4 no bytes", rx_n, 0);

    // R6: line stuck low
    do_arm(4);
    line = 1'b0; cyc(1000); line = 1'b1;
    wait_done(100);
    chk(done_n == 1 && last_st == 8'hFF, "R6 stuck low", last_st, 8'hFF);

    frame(2, 0, 3, 1'b1, 1'b0, "tie");
    frame(0, 0, 3, 1'b0, 1'b0, "empty");
    frame(1, 3, 3, 1'b0, 1'b0, "partial");
    frame(0, 7, 3, 1'b0, 1'b0, "partial7");
    frame(3, 0, 3, 1'b0, 1'b0, "full");
    frame(3, 0, 2, 1'b0, 1'b0, "ovf");
    frame(1, 0, 0, 1'b0, 1'b0, "ovf0");
    frame(2, 0, 4, 1'b0, 1'b1, "R10 disturb");

    for (int k = 0; k < 22; k++) begin
      int nb, xb, mb;
      nb = $urandom_range(0, 4);
      xb = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      mb = $urandom_range(0, 5);
      frame(nb, xb, mb, 1'b0, ($urandom_range(0, 4) == 0) && nb > 0, "rand");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule